// File: doc/BRIEF.md
# Multiplexed Eight-Digit LED Display Scanner

This block drives a common-cathode, eight-digit seven-segment LED display one digit at a time. It takes eight BCD digits from the measurement latches, an overflow flag, the index of the digit that carries the decimal point, and display-test and display-off controls. It steps through the digits in turn on a slow scan tick. Each digit slot opens with a short dark gap, so that the previous digit's pattern cannot ghost onto the next one. The rest of the slot lights the digit.

The segment pattern for a slot is built and registered at the moment the slot's lit phase begins. It holds until the slot ends, so mid-slot changes on the inputs never reach the display. The pattern comes from the BCD decoder, from leading-zero suppression, from the decimal-point placement and from the overflow lamp, which is the decimal point of the top digit. Display test overrides the pattern, and display off overrides everything. The current digit strobe is exported at all times so that a neighbouring decoder can sample inputs that are multiplexed on the digit lines.

A two-state machine sequences each slot. SCAN_GAP counts BLANK_TICKS ticks with all outputs dark, then takes the transition "open" to SCAN_LIT. SCAN_LIT counts SLOT_TICKS-BLANK_TICKS ticks, then takes the transition "close" back to SCAN_GAP and advances the digit index from the least significant digit toward the most significant, wrapping from digit 8 to digit 1. With a 2 µs tick, the defaults give 6 µs dark plus 244 µs lit per slot, which is a 500 Hz frame.

Top module: `led_scan_driver`

## Requirements
- R1: While reset is asserted, and in the first gap after reset, `dig_en` and `seg_out` are all zero and `strobe` selects digit 1 (`strobe` = 8'b0000_0001).
- R2: Digits are scanned in the order 1,2,…,8,1,… with one slot of SLOT_TICKS scan ticks per digit, and at most one `dig_en` bit is high at any time. Bit k of `dig_en` and of `strobe` is digit k+1, and digit 1 is the least significant digit.
- R3: During the first BLANK_TICKS ticks of every slot, `dig_en` and `seg_out` are all zero.
- R4: `dig_en` and `seg_out` change only when a slot's lit phase begins or ends, so a change on `digits` during a lit phase does not alter the lit pattern.
- R5: The segment encoding is bit0=a, bit1=b, bit2=c, bit3=d, bit4=e, bit5=f, bit6=g and bit7=decimal point, active high. BCD 0..9 map to 0x3F,0x06,0x5B,0x4F,0x66,0x6D,0x7D,0x07,0x7F,0x6F in bits 6:0, and codes 10..15 light no segment.
- R6: A zero digit above the decimal-point digit (`dp_sel`) is dark when every more significant digit is also zero. The decimal-point digit itself and the digits below it are always shown.
- R7: When `ovf` is high, leading-zero suppression is off and every digit shows its glyph.
- R8: The decimal point lights on digit `dp_sel`+1 for `dp_sel` 0..6. `dp_sel` = 7 lights no decimal point, because the top digit's point is reserved for overflow.
- R9: When `ovf` is high, the decimal point of digit 8 is lit.
- R10: With `disp_test` high, every lit digit shows `seg_out` = 0xFF.
- R11: With `disp_off` high, `dig_en` and `seg_out` stay zero, even when `disp_test` is also high.
- R12: `strobe` is one-hot on the digit of the current slot throughout its gap and lit phases, and any nonzero `dig_en` equals `strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | One-cycle pulse that advances the slot timer |
| digits | input | 32 | BCD digits; nibble k is digit k+1 |
| ovf | input | 1 | Overflow flag |
| dp_sel | input | 3 | Index of the decimal-point digit (0 = digit 1) |
| disp_test | input | 1 | Light all segments and points |
| disp_off | input | 1 | Turn the whole display dark |
| dig_en | output | 8 | One-hot digit enables, active high |
| seg_out | output | 8 | Segments a..g and decimal point, active high |
| strobe | output | 8 | Current slot digit, one-hot, for input demultiplexing |

## Verification
The assertions take for granted that `scan_tick` is a single-cycle pulse and that the control and data inputs are free to change at any clock. They rely only on the registered scan state: a one-hot strobe that rotates one place at a time, enables that match the strobe, dark segments whenever no digit is enabled, and a stable pattern while the same digit stays lit. The stimulus changes inputs a quarter cycle after the rising edge and pulses the tick on its own schedule. Several patterns are held for at least two frames before directed checks. One change is made deliberately in the middle of a lit phase to exercise R4.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
    typedef enum logic [0:0] {
        SCAN_GAP = 1'b0,
        SCAN_LIT = 1'b1
    } scan_state_e;

    localparam int SEG_W  = 8;
    localparam int DP_BIT = 7;
    localparam int BCD_W  = 4;
endpackage

// File: rtl/led_scan_timer.sv
module led_scan_timer #(
    parameter int NUM_DIGITS  = 8,
    parameter int SLOT_TICKS  = 125,
    parameter int BLANK_TICKS = 3,
    localparam int IDX_W      = $clog2(NUM_DIGITS),
    localparam int CNT_W      = $clog2(SLOT_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [IDX_W-1:0] idx,
    output logic             lit_start,
    output logic             lit_end
);
    import led_scan_pkg::*;

    localparam int LIT_TICKS = SLOT_TICKS - BLANK_TICKS;

    scan_state_e      state;
    logic [CNT_W-1:0] tcnt;

    // State register: slot phase, tick counter and digit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SCAN_GAP;
            tcnt  <= '0;
            idx   <= '0;
        end else if (tick) begin
            unique case (state)
                SCAN_GAP: begin
                    if (tcnt == CNT_W'(BLANK_TICKS - 1)) begin
                        state <= SCAN_LIT;
                        tcnt  <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                SCAN_LIT: begin
                    if (tcnt == CNT_W'(LIT_TICKS - 1)) begin
                        state <= SCAN_GAP;
                        tcnt  <= '0;
                        idx   <= (idx == IDX_W'(NUM_DIGITS - 1)) ? '0 : idx + 1'b1;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Transition strobes
    always_comb begin
        lit_start = 1'b0;
        lit_end   = 1'b0;
        unique case (state)
            SCAN_GAP: lit_start = tick && (tcnt == CNT_W'(BLANK_TICKS - 1));
            SCAN_LIT: lit_end   = tick && (tcnt == CNT_W'(LIT_TICKS - 1));
        endcase
    end
endmodule

// File: rtl/led_zero_blank.sv
module led_zero_blank #(
    parameter int NUM_DIGITS = 8,
    localparam int IDX_W     = $clog2(NUM_DIGITS)
) (
    input  logic [NUM_DIGITS*4-1:0] digits,
    input  logic [IDX_W-1:0]        dp_sel,
    input  logic                    ovf,
    output logic [NUM_DIGITS-1:0]   blank
);
    logic [NUM_DIGITS-1:0] zero_up;

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
        // digit k and everything more significant is zero
        assign zero_up[k] = (digits[NUM_DIGITS*4-1 : k*4] == '0);
        assign blank[k]   = !ovf && (k > int'(dp_sel)) && zero_up[k];
    end
endmodule

// File: rtl/led_seg_decode.sv
module led_seg_decode (
    input  logic [3:0] bcd,
    output logic [6:0] glyph
);
    always_comb begin
        case (bcd)
            4'd0:    glyph = 7'h3F;
            4'd1:    glyph = 7'h06;
            4'd2:    glyph = 7'h5B;
            4'd3:    glyph = 7'h4F;
            4'd4:    glyph = 7'h66;
            4'd5:    glyph = 7'h6D;
            4'd6:    glyph = 7'h7D;
            4'd7:    glyph = 7'h07;
            4'd8:    glyph = 7'h7F;
            4'd9:    glyph = 7'h6F;
            default: glyph = 7'h00;
        endcase
    end
endmodule

// File: rtl/led_scan_driver.sv
module led_scan_driver #(
    parameter int NUM_DIGITS  = 8,
    parameter int SLOT_TICKS  = 125,
    parameter int BLANK_TICKS = 3,
    localparam int IDX_W      = $clog2(NUM_DIGITS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scan_tick,
    input  logic [NUM_DIGITS*4-1:0] digits,
    input  logic                    ovf,
    input  logic [IDX_W-1:0]        dp_sel,
    input  logic                    disp_test,
    input  logic                    disp_off,
    output logic [NUM_DIGITS-1:0]   dig_en,
    output logic [7:0]              seg_out,
    output logic [NUM_DIGITS-1:0]   strobe
);
    import led_scan_pkg::*;

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_DIGITS - 1);

    logic [IDX_W-1:0]      idx;
    logic                  lit_start;
    logic                  lit_end;
    logic [3:0]            cur_bcd;
    logic [6:0]            cur_glyph;
    logic [NUM_DIGITS-1:0] blank;
    logic [SEG_W-1:0]      pattern;

    led_scan_timer #(
        .NUM_DIGITS (NUM_DIGITS),
        .SLOT_TICKS (SLOT_TICKS),
        .BLANK_TICKS(BLANK_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (scan_tick),
        .idx      (idx),
        .lit_start(lit_start),
        .lit_end  (lit_end)
    );

    led_zero_blank #(.NUM_DIGITS(NUM_DIGITS)) u_blank (
        .digits(digits),
        .dp_sel(dp_sel),
        .ovf   (ovf),
        .blank (blank)
    );

    assign cur_bcd = digits[{idx, 2'b00} +: BCD_W];

    led_seg_decode u_dec (
        .bcd  (cur_bcd),
        .glyph(cur_glyph)
    );

    assign strobe = NUM_DIGITS'(1) << idx;

    // Pattern for the digit of the current slot
    always_comb begin
        if (disp_test) begin
            pattern = '1;
        end else begin
            pattern[6:0]    = blank[idx] ? 7'h00 : cur_glyph;
            pattern[DP_BIT] = ((idx == dp_sel) && (idx != TOP_IDX)) ||
                              ((idx == TOP_IDX) && ovf);
        end
    end

    // Output registers: loaded when the lit phase opens, cleared when it closes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dig_en  <= '0;
            seg_out <= '0;
        end else if (lit_start) begin
            dig_en  <= disp_off ? '0 : strobe;
            seg_out <= disp_off ? '0 : pattern;
        end else if (lit_end) begin
            dig_en  <= '0;
            seg_out <= '0;
        end
    end
endmodule

// File: rtl/led_scan_checker.sv
module led_scan_checker #(
    parameter int NUM_DIGITS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_DIGITS-1:0] dig_en,
    input logic [7:0]            seg_out,
    input logic [NUM_DIGITS-1:0] strobe
);
    logic [NUM_DIGITS-1:0] strobe_rot;
    assign strobe_rot = {strobe[NUM_DIGITS-2:0], strobe[NUM_DIGITS-1]};

    AST_DIG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_en)); // R2

    AST_STROBE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(strobe) |-> (strobe == $past(strobe_rot))); // R2

    AST_DARK_UNLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en == '0) |-> (seg_out == '0)); // R3

    AST_GAP_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((dig_en != '0) && ($past(dig_en) != '0)) |-> (dig_en == $past(dig_en))); // R3

    AST_LIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((dig_en != '0) && (dig_en == $past(dig_en))) |-> $stable(seg_out)); // R4

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(strobe)); // R12

    AST_DIG_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en != '0) |-> (dig_en == strobe)); // R12
endmodule

bind led_scan_driver led_scan_checker #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .dig_en (dig_en),
    .seg_out(seg_out),
    .strobe (strobe)
);

// File: tb/tb_led_scan_driver.sv
module tb_led_scan_driver;
    localparam int SLOT  = 8;
    localparam int BLANK = 2;
    localparam int TDIV  = 3;
    localparam int FRAME = 8 * SLOT * TDIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_tick = 1'b0;
    logic [31:0] digits = '0;
    logic        ovf = 1'b0;
    logic [2:0]  dp_sel = 3'd7;
    logic        disp_test = 1'b0;
    logic        disp_off = 1'b0;
    logic [7:0]  dig_en;
    logic [7:0]  seg_out;
    logic [7:0]  strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    led_scan_driver #(.NUM_DIGITS(8), .SLOT_TICKS(SLOT), .BLANK_TICKS(BLANK)) dut (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .digits(digits),
        .ovf(ovf), .dp_sel(dp_sel), .disp_test(disp_test), .disp_off(disp_off),
        .dig_en(dig_en), .seg_out(seg_out), .strobe(strobe)
    );

    always #10 clk = ~clk;

    initial begin
        int tc = 0;
        forever begin
            @(posedge clk);
            #5;
            tc = (tc == TDIV - 1) ? 0 : tc + 1;
            scan_tick = (tc == 0);
        end
    end

    function automatic logic [6:0] glyph(input int v);
        logic [6:0] tbl [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                                 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
        if (v > 9) return 7'h00;
        return tbl[v];
    endfunction

    function automatic logic [7:0] model_pattern(input int k);
        logic [7:0] p;
        bit leading = 1'b1;
        bit dark = 1'b0;
        if (disp_test) return 8'hFF;
        for (int j = 7; j >= k; j--) begin
            int v = int'(digits[j*4 +: 4]);
            if (!(leading && !ovf && j > int'(dp_sel) && v == 0)) leading = 1'b0;
            if (j == k) dark = leading;
        end
        p[6:0] = dark ? 7'h00 : glyph(int'(digits[k*4 +: 4]));
        p[7] = (k == int'(dp_sel) && k != 7) || (k == 7 && ovf);
        return p;
    endfunction

    // Behavioural reference: position in slot and digit number
    int m_pos = 0;
    int m_idx = 0;
    logic [7:0] m_dig = '0;
    logic [7:0] m_seg = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_idx = 0; m_dig = '0; m_seg = '0;
        end else if (scan_tick) begin
            m_pos = m_pos + 1;
            if (m_pos == BLANK) begin
                m_dig = disp_off ? 8'h00 : 8'(1 << m_idx);
                m_seg = disp_off ? 8'h00 : model_pattern(m_idx);
            end else if (m_pos == SLOT) begin
                m_pos = 0;
                m_idx = (m_idx + 1) % 8;
                m_dig = '0;
                m_seg = '0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (dig_en !== m_dig) begin
                errors++;
                $display("FAIL R2 dig_en actual=%b expected=%b", dig_en, m_dig);
            end
            checks++;
            if (seg_out !== m_seg) begin
                errors++;
                $display("FAIL R5 seg_out actual=%h expected=%h", seg_out, m_seg);
            end
            checks++;
            if (strobe !== 8'(1 << m_idx)) begin
                errors++;
                $display("FAIL R12 strobe actual=%b expected=%b", strobe, 8'(1 << m_idx));
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_in(input logic [31:0] d, input logic [2:0] dp, input logic o,
                          input logic t, input logic f);
        @(posedge clk);
        #5;
        digits = d; dp_sel = dp; ovf = o; disp_test = t; disp_off = f;
    endtask

    task automatic settle();
        repeat (2 * FRAME) @(negedge clk);
    endtask

    task automatic wait_digit(input int k);
        bit seen = 1'b0;
        for (int n = 0; n < 3 * FRAME; n++) begin
            @(negedge clk);
            if (dig_en == 8'(1 << k)) begin
                seen = 1'b1;
                break;
            end
        end
        if (!seen) chk("R2 digit never lit", dig_en, 8'(1 << k));
    endtask

    task automatic see(input int k, input string tag, input logic [7:0] exp);
        wait_digit(k);
        chk(tag, seg_out, exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset dig_en", dig_en, 8'h00);
        chk("R1 reset seg_out", seg_out, 8'h00);
        chk("R1 reset strobe", strobe, 8'h01);
        @(posedge clk);
        #5 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first gap dig_en", dig_en, 8'h00);
        chk("R1 first gap strobe", strobe, 8'h01);

        // Plain digits 1..8, no point
        set_in(32'h8765_4321, 3'd7, 1'b0, 1'b0, 1'b0);
        settle();
        for (int k = 0; k < 8; k++) see(k, "R5 glyph", {1'b0, glyph(k + 1)});

        // Non-decimal codes are dark
        set_in(32'hFEDC_BA98, 3'd0, 1'b0, 1'b0, 1'b0);
        settle();
        see(0, "R8 point on digit 1", 8'hFF);
        see(1, "R5 nine", 8'h6F);
        see(2, "R5 code 10 dark", 8'h00);
        see(7, "R5 code 15 dark", 8'h00);

        // Leading zeros above point
        set_in(32'h0000_0120, 3'd0, 1'b0, 1'b0, 1'b0);
        settle();
        see(0, "R6 point digit zero shown", 8'hBF);
        see(1, "R6 two", 8'h5B);
        see(2, "R6 one", 8'h06);
        see(3, "R6 leading zero dark", 8'h00);
        see(7, "R6 top zero dark", 8'h00);

        set_in(32'h0000_0000, 3'd3, 1'b0, 1'b0, 1'b0);
        settle();
        see(2, "R6 zero right of point", 8'h3F);
        see(3, "R8 point on digit 4", 8'hBF);
        see(4, "R6 zero left of point dark", 8'h00);

        // Overflow disables suppression and lights top point
        set_in(32'h0000_0000, 3'd3, 1'b1, 1'b0, 1'b0);
        settle();
        see(4, "R7 zero shown on overflow", 8'h3F);
        see(7, "R9 overflow lamp", 8'hBF);

        set_in(32'h5000_0000, 3'd7, 1'b0, 1'b0, 1'b0);
        settle();
        see(6, "R6 inner zero shown", 8'h3F);
        see(7, "R8 top point reserved", 8'h6D);
        set_in(32'h5000_0000, 3'd7, 1'b1, 1'b0, 1'b0);
        settle();
        see(7, "R9 overflow on five", 8'hED);

        // Display test
        set_in(32'h0000_0000, 3'd0, 1'b0, 1'b1, 1'b0);
        settle();
        see(0, "R10 test digit 1", 8'hFF);
        see(7, "R10 test digit 8", 8'hFF);

        // Display off beats test
        set_in(32'h1234_5678, 3'd0, 1'b0, 1'b1, 1'b1);
        settle();
        begin
            int lit = 0;
            for (int n = 0; n < FRAME; n++) begin
                @(negedge clk);
                if (dig_en != 0 || seg_out != 0) lit++;
            end
            checks++;
            if (lit != 0) begin
                errors++;
                $display("FAIL R11 lit cycles actual=%0d expected=0", lit);
            end
        end

        // Gap and strobe
        set_in(32'h0000_1234, 3'd0, 1'b0, 1'b0, 1'b0);
        settle();
        wait_digit(2);
        while (dig_en != 0) @(negedge clk);
        chk("R3 gap segments", seg_out, 8'h00);
        chk("R12 strobe in gap", strobe, 8'h08);

        // Mid-slot change ignored
        see(3, "R5 digit 4 one", 8'h06);
        set_in(32'h0000_8888, 3'd0, 1'b0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        chk("R4 held dig_en", dig_en, 8'h08);
        chk("R4 held seg_out", seg_out, 8'h06);
        settle();
        see(3, "R4 new value next frame", 8'h7F);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule